// File: doc/BRIEF.md
# Legacy Audio I/O Address Decoder

This block sits behind the I/O target logic of an audio controller. It turns one registered I/O address phase into a select for one of four legacy sound sub-blocks: the FM synthesizer, the Sound Blaster style DSP and mixer, the MPU-401 MIDI port and the joystick port. Along with the select it gives a sub-register code and the offset inside the window. A `claim` output tells the bus interface to answer the cycle. The base addresses, the enable bits, the alias mode and the global legacy disable all come from configuration inputs. The decoder itself has only one state bit. That bit records which of the two FM register arrays the last FM address write selected.

All windows can be decoded on ten address bits, in which case bits 15..10 are ignored and the windows repeat through the I/O space. They can also be decoded on all sixteen bits. The Sound Blaster window has two jobs. Its low four ports and its offset 8 lead to the FM registers, and this works even when the FM window itself is disabled. The other offsets of that window reach the mixer and the DSP. Several ports are different registers on read and on write.

Top module: `legacy_io_decode`

## Requirements
- R1: With `cfg_dec10`=1, window matching ignores address bits 15..10. With `cfg_dec10`=0, all 16 bits take part in the match.
- R2: The MPU window is two ports wide, and base bit 0 is ignored. Offset 0 gives code 10 (data). Offset 1 gives code 11 (status) on read and code 12 (command) on write.
- R3: The joystick window is the single port equal to its base, matched on bits 9..0 or 15..0. It gives code 13 and `sub_off`=0.
- R4: The FM window is four ports wide. Offset 0 gives code 1 (status) on read and code 2 (array-0 address) on write. Offset 1 gives code 3 (array-0 data). Offset 2 gives code 4 (array-1 address) on write and code 1 on read. Offset 3 gives code 5 (array-1 data).
- R5: The Sound Blaster window is sixteen ports wide. Offsets 0..3 raise `sel_fm` with the R4 codes. Offset 8 raises `sel_fm` with code 1 on read and code 2 on write. Offset 4 gives code 6 (mixer address), offset 5 gives code 7 (mixer data) and offset 6 gives code 8 (DSP reset). Every other offset gives code 9 (DSP port). Offsets 4..7 and 9..15 raise `sel_sb`. `sub_off` is the offset within the window.
- R6: While `cfg_sb_en`=1, the FM registers can be reached through the Sound Blaster window even when `cfg_fm_en`=0. When both enables are 0, nothing claims those ports.
- R7: `fm_array` is 0 after reset. It becomes 0 in the cycle after a code-2 access and 1 in the cycle after a code-4 access. At any other time it holds.
- R8: When `io_valid`=0 or `cfg_legacy_off`=1, nothing is claimed.
- R9: When windows overlap, the priority is Sound Blaster, then FM, then MPU, then joystick. At most one select is high.
- R10: `claim` is the OR of the four selects. When nothing is claimed, `reg_id` and `sub_off` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_valid | input | 1 | Registered I/O address phase is valid |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O address |
| cfg_legacy_off | input | 1 | Claim no legacy address |
| cfg_dec10 | input | 1 | 1 = ten-bit alias decode, 0 = full decode |
| cfg_sb_en | input | 1 | Sound Blaster window enable |
| cfg_fm_en | input | 1 | FM window enable |
| cfg_mpu_en | input | 1 | MPU window enable |
| cfg_joy_en | input | 1 | Joystick window enable |
| cfg_sb_base | input | 16 | Sound Blaster window base |
| cfg_fm_base | input | 16 | FM window base |
| cfg_mpu_base | input | 16 | MPU window base |
| cfg_joy_base | input | 16 | Joystick port address |
| claim | output | 1 | Respond to this cycle |
| sel_sb | output | 1 | Sound Blaster DSP/mixer select |
| sel_fm | output | 1 | FM synthesizer select |
| sel_mpu | output | 1 | MPU select |
| sel_joy | output | 1 | Joystick select |
| reg_id | output | 4 | Sub-register code (see R2..R5) |
| sub_off | output | 4 | Offset inside the claimed window |
| fm_array | output | 1 | FM array last addressed |

## Verification
Two functions can fall in the same cycle: an FM address write that reaches the FM registers through the Sound Blaster window, and the update of the array flag. A second pair is the priority choice between overlapping windows and the alias decode. Both pairs are provoked by configurations that stack the windows on top of one another and disable the FM window, while every ten-bit address is swept with varied high bits for both reads and writes. An arithmetic model in the bench gives the expected select, code and offset for each cycle, and it tracks the array flag, which is compared on the following cycle.

// File: rtl/legacy_io_decode.sv
module legacy_io_decode #(
  parameter int AW      = 16,
  parameter int ALIAS_W = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_valid,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic          cfg_legacy_off,
  input  logic          cfg_dec10,
  input  logic          cfg_sb_en,
  input  logic          cfg_fm_en,
  input  logic          cfg_mpu_en,
  input  logic          cfg_joy_en,
  input  logic [AW-1:0] cfg_sb_base,
  input  logic [AW-1:0] cfg_fm_base,
  input  logic [AW-1:0] cfg_mpu_base,
  input  logic [AW-1:0] cfg_joy_base,
  output logic          claim,
  output logic          sel_sb,
  output logic          sel_fm,
  output logic          sel_mpu,
  output logic          sel_joy,
  output logic [3:0]    reg_id,
  output logic [3:0]    sub_off,
  output logic          fm_array
);
  localparam int SB_LO  = 4;
  localparam int FM_LO  = 2;
  localparam int MPU_LO = 1;

  localparam logic [3:0] ID_NONE  = 4'd0;
  localparam logic [3:0] ID_FMST  = 4'd1;
  localparam logic [3:0] ID_FMA0  = 4'd2;
  localparam logic [3:0] ID_FMD0  = 4'd3;
  localparam logic [3:0] ID_FMA1  = 4'd4;
  localparam logic [3:0] ID_FMD1  = 4'd5;
  localparam logic [3:0] ID_MIXA  = 4'd6;
  localparam logic [3:0] ID_MIXD  = 4'd7;
  localparam logic [3:0] ID_DSPR  = 4'd8;
  localparam logic [3:0] ID_DSP   = 4'd9;
  localparam logic [3:0] ID_MPUD  = 4'd10;
  localparam logic [3:0] ID_MPUS  = 4'd11;
  localparam logic [3:0] ID_MPUC  = 4'd12;
  localparam logic [3:0] ID_JOY   = 4'd13;

  logic [AW-1:0] amask, d_sb, d_fm, d_mpu, d_joy;
  logic          live, sb_hit, fm_hit, mpu_hit, joy_hit, sb_to_fm;
  logic [3:0]    sb_off;
  logic [1:0]    fport;

  assign amask = cfg_dec10 ? {{(AW-ALIAS_W){1'b0}}, {ALIAS_W{1'b1}}} : '1;
  assign d_sb  = (io_addr ^ cfg_sb_base)  & amask;
  assign d_fm  = (io_addr ^ cfg_fm_base)  & amask;
  assign d_mpu = (io_addr ^ cfg_mpu_base) & amask;
  assign d_joy = (io_addr ^ cfg_joy_base) & amask;

  assign live    = io_valid & ~cfg_legacy_off;
  assign sb_hit  = live & cfg_sb_en  & (d_sb[AW-1:SB_LO]   == '0);
  assign fm_hit  = live & cfg_fm_en  & (d_fm[AW-1:FM_LO]   == '0) & ~sb_hit;
  assign mpu_hit = live & cfg_mpu_en & (d_mpu[AW-1:MPU_LO] == '0) & ~sb_hit & ~fm_hit;
  assign joy_hit = live & cfg_joy_en & (d_joy == '0) & ~sb_hit & ~fm_hit & ~mpu_hit;

  assign sb_off   = io_addr[3:0];
  assign sb_to_fm = (sb_off < 4'd4) | (sb_off == 4'd8);

  assign sel_sb  = sb_hit & ~sb_to_fm;
  assign sel_fm  = fm_hit | (sb_hit & sb_to_fm);
  assign sel_mpu = mpu_hit;
  assign sel_joy = joy_hit;
  assign claim   = sel_sb | sel_fm | sel_mpu | sel_joy;

  assign fport = sb_hit ? ((sb_off == 4'd8) ? 2'd0 : sb_off[1:0]) : io_addr[1:0];

  always_comb begin
    reg_id = ID_NONE;
    if (sel_fm) begin
      case (fport)
        2'd0:    reg_id = io_wr ? ID_FMA0 : ID_FMST;
        2'd1:    reg_id = ID_FMD0;
        2'd2:    reg_id = io_wr ? ID_FMA1 : ID_FMST;
        default: reg_id = ID_FMD1;
      endcase
    end else if (sel_sb) begin
      case (sb_off)
        4'd4:    reg_id = ID_MIXA;
        4'd5:    reg_id = ID_MIXD;
        4'd6:    reg_id = ID_DSPR;
        default: reg_id = ID_DSP;
      endcase
    end else if (mpu_hit) begin
      reg_id = io_addr[0] ? (io_wr ? ID_MPUC : ID_MPUS) : ID_MPUD;
    end else if (joy_hit) begin
      reg_id = ID_JOY;
    end
  end

  assign sub_off = sb_hit  ? sb_off :
                   fm_hit  ? {2'b00, io_addr[1:0]} :
                   mpu_hit ? {3'b000, io_addr[0]} : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fm_array <= 1'b0;
    else if (reg_id == ID_FMA0) fm_array <= 1'b0;
    else if (reg_id == ID_FMA1) fm_array <= 1'b1;
  end
endmodule

module legacy_io_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_valid,
  input logic       io_wr,
  input logic       cfg_legacy_off,
  input logic       cfg_sb_en,
  input logic       cfg_fm_en,
  input logic       claim,
  input logic       sel_sb,
  input logic       sel_fm,
  input logic       sel_mpu,
  input logic       sel_joy,
  input logic [3:0] reg_id,
  input logic [3:0] sub_off,
  input logic       fm_array
);
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sb, sel_fm, sel_mpu, sel_joy}));
  a_r8_legacy_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legacy_off |-> !claim);
  a_r8_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !claim);
  a_r7_arr1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_id == 4'd4) |=> fm_array);
  a_r7_arr0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_id == 4'd2) |=> !fm_array);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_id == 4'd2 || reg_id == 4'd4) |=> $stable(fm_array));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |-> (reg_id == 4'd0 && sub_off == 4'd0));
  a_r6_fm_path: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fm && !cfg_fm_en) |-> cfg_sb_en);
  a_r4_addr_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_id == 4'd2 || reg_id == 4'd4) |-> io_wr);
endmodule

bind legacy_io_decode legacy_io_decode_chk u_chk (.*);

// File: tb/sim_legacy_io_decode.sv
`timescale 1ns/1ps
module sim_legacy_io_decode;
  logic clk = 1'b0, rst_n = 1'b0;
  logic io_valid = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic cfg_legacy_off = 1'b0, cfg_dec10 = 1'b1;
  logic cfg_sb_en = 1'b1, cfg_fm_en = 1'b1, cfg_mpu_en = 1'b1, cfg_joy_en = 1'b1;
  logic [15:0] cfg_sb_base = 16'h0220, cfg_fm_base = 16'h0388;
  logic [15:0] cfg_mpu_base = 16'h0330, cfg_joy_base = 16'h0201;
  logic claim, sel_sb, sel_fm, sel_mpu, sel_joy, fm_array;
  logic [3:0] reg_id, sub_off;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_flag = 1'b0;

  always #2.5 clk = ~clk;

  legacy_io_decode u0 (.*);

  function automatic bit inwin(input logic [15:0] a, input logic [15:0] b, input int span);
    logic [15:0] m;
    m = cfg_dec10 ? 16'h03FF : 16'hFFFF;
    return (((a ^ b) & m) & ~16'(span - 1)) == 16'h0;
  endfunction

  function automatic logic [3:0] fm_code(input int p, input logic w);
    if (p == 1) return 4'd3;
    if (p == 3) return 4'd5;
    if (p == 0) return w ? 4'd2 : 4'd1;
    return w ? 4'd4 : 4'd1;
  endfunction

  // {claim, sb, fm, mpu, joy, id, off}
  function automatic logic [12:0] model(input logic [15:0] a, input logic w);
    int o;
    if (!io_valid || cfg_legacy_off) return '0;
    if (cfg_sb_en && inwin(a, cfg_sb_base, 16)) begin
      o = a % 16;
      if (o < 4)       return {5'b10100, fm_code(o, w), 4'(o)};
      if (o == 8)      return {5'b10100, (w ? 4'd2 : 4'd1), 4'd8};
      if (o == 4)      return {5'b11000, 4'd6, 4'd4};
      if (o == 5)      return {5'b11000, 4'd7, 4'd5};
      if (o == 6)      return {5'b11000, 4'd8, 4'd6};
      return {5'b11000, 4'd9, 4'(o)};
    end
    if (cfg_fm_en && inwin(a, cfg_fm_base, 4))
      return {5'b10100, fm_code(a % 4, w), 4'(a % 4)};
    if (cfg_mpu_en && inwin(a, cfg_mpu_base, 2)) begin
      if (a % 2 == 0) return {5'b10010, 4'd10, 4'd0};
      return {5'b10010, (w ? 4'd12 : 4'd11), 4'd1};
    end
    if (cfg_joy_en && inwin(a, cfg_joy_base, 1)) return {5'b10001, 4'd13, 4'd0};
    return '0;
  endfunction

  task automatic apply(input logic v, input logic [15:0] a, input logic w, input string tag);
    logic [12:0] e, g;
    string t;
    @(negedge clk);
    checks++;
    if (fm_array !== exp_flag) begin
      errors++;
      $display("FAIL R7 fm_array actual=%0b expected=%0b", fm_array, exp_flag);
    end
    io_valid = v; io_addr = a; io_wr = w;
    #1;
    e = model(a, w);
    g = {claim, sel_sb, sel_fm, sel_mpu, sel_joy, reg_id, sub_off};
    t = tag;
    if (t == "") begin
      if (!e[12])                t = "R10";
      else if (a[15:10] != 0)    t = "R1";
      else if (e[10] || (e[11] && e[7:4] != 0 && cfg_sb_en && inwin(a, cfg_sb_base, 16))) t = "R5";
      else if (e[9])             t = "R4";
      else if (e[8])             t = "R2";
      else                       t = "R3";
    end
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0b actual=%h expected=%h", t, a, w, g, e);
    end
    if (e[7:4] == 4'd2) exp_flag = 1'b0;
    else if (e[7:4] == 4'd4) exp_flag = 1'b1;
  endtask

  task automatic sweep(input int k);
    for (int i = 0; i < 1024; i++) begin
      logic [5:0] hi;
      hi = (i % 3 == 0) ? 6'd0 : 6'((i * 7 + k) % 64);
      apply(1'b1, {hi, 10'(i)}, 1'b0, "");
      apply(1'b1, {hi, 10'(i)}, 1'b1, "");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (fm_array !== 1'b0 || claim !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset actual=%0b/%0b expected=0/0", fm_array, claim);
    end

    // R7 ordering: array-1 address, then data, then array-0 through the SB window offset 8
    apply(1'b1, 16'h038A, 1'b1, "R7");
    apply(1'b1, 16'h0389, 1'b1, "R7");
    apply(1'b1, 16'h0228, 1'b1, "R7");
    apply(1'b1, 16'h0222, 1'b1, "R7");
    apply(1'b1, 16'h0228, 1'b0, "R7");
    // R8: invalid and legacy disable
    apply(1'b0, 16'h0220, 1'b1, "R8");
    cfg_legacy_off = 1'b1;
    apply(1'b1, 16'h0388, 1'b1, "R8");
    apply(1'b1, 16'h0330, 1'b0, "R8");
    cfg_legacy_off = 1'b0;

    sweep(0);
    cfg_dec10 = 1'b0;
    sweep(5);
    cfg_dec10 = 1'b1;

    // R9: stacked windows
    cfg_sb_base = 16'h0380; cfg_fm_base = 16'h0388;
    cfg_mpu_base = 16'h038A; cfg_joy_base = 16'h038B;
    apply(1'b1, 16'h038A, 1'b1, "R9");
    sweep(11);
    cfg_sb_en = 1'b0;
    apply(1'b1, 16'h038A, 1'b1, "R9");
    apply(1'b1, 16'h038C, 1'b1, "R9");
    sweep(17);

    // R6: FM window disabled, SB window still reaches FM
    cfg_sb_en = 1'b1; cfg_fm_en = 1'b0;
    cfg_sb_base = 16'h0220; cfg_fm_base = 16'h0388;
    cfg_mpu_base = 16'h0330; cfg_joy_base = 16'h0201;
    apply(1'b1, 16'h0222, 1'b1, "R6");
    apply(1'b1, 16'h0388, 1'b1, "R6");
    sweep(23);
    cfg_sb_en = 1'b0;
    apply(1'b1, 16'h0221, 1'b1, "R6");
    apply(1'b1, 16'h0220, 1'b0, "R6");

    apply(1'b0, 16'h0000, 1'b0, "R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule